// File: doc/BRIEF.md
# Multi-format serial audio input receiver

This block receives stereo audio samples from a three-wire serial bus. The bus has a bit clock, a word-select line and a data line, and an external master drives all three. The block never drives the bus. The bit clock is the block's clock, and data and word select are both sampled on its rising edge.

Two framings are accepted:

- **Delayed-MSB (I2S) framing:** the most significant bit arrives one bit clock after the word-select change.
- **LSB-justified framing:** the least significant bit is the last bit before the word-select change.

The word length is selected as 16, 18, 20 or 24 bits. Every captured word is left-aligned into a fixed 24-bit sample. Missing low bits are filled with zeros, and bits beyond the selected length are dropped.

Word select low carries the left channel and high carries the right channel. Once a left word and the right word that follows it have both been captured, the pair is presented with a one-cycle valid pulse. A frame-error flag is delivered with the pulse. It is set when either slot held more than 32 bit clocks or when the two slots differ in length.

Top module: `sa_rx`

## Requirements
- R1: While reset is asserted, and after reset until the first completed frame, `left_o` and `right_o` are zero and `valid_o` and `frame_err_o` are low.
- R2: With `fmt_i`=0 (I2S framing), the bit sampled one rising edge after word select is first seen changed is the MSB of the new slot. A slot with word select 0 is the left channel and a slot with word select 1 is the right channel.
- R3: With `fmt_i`=1 (LSB-justified framing), the word is the last N bits sampled before word select is first seen changed, with the last of them as LSB.
- R4: `wlen_i` selects N: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24. The N-bit word occupies bits 23 down to 24-N of the output, and the remaining low bits are zero.
- R5: In I2S framing, data bits after the first N of a slot are discarded. This includes slots longer than 24 bits.
- R6: `valid_o` is high for exactly one cycle, one rising edge after the edge on which word select is first sampled low following a right slot. This happens only if the left slot before that right slot was captured. The partial slot in progress when reset is released is discarded.
- R7: `frame_err_o` is updated only together with `valid_o`. It is 1 if either slot of that frame exceeded 32 bit clocks or if the two slots had different bit-clock counts, and 0 otherwise.
- R8: `left_o`, `right_o` and `frame_err_o` hold their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bck_i | input | 1 | Serial bit clock from the external master; the block's clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ws_i | input | 1 | Word select: 0 marks the left slot, 1 marks the right slot |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 1 | Framing: 0 selects I2S, 1 selects LSB-justified |
| wlen_i | input | 2 | Word length: 0=16, 1=18, 2=20, 3=24 bits |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle pulse marking a new sample pair |
| frame_err_o | output | 1 | Framing error of the pair marked by the latest pulse |

## Verification
A slot closes on the rising edge where the changed word select is first sampled. Its word is formed combinationally at that edge and registered there. The outputs and the valid pulse therefore appear one edge after the right slot closes, and they stay unchanged until the next such edge.

The bench model updates on every rising edge from the same sampled bits. The outputs are compared 2 ns after that edge, so that one-edge latency is matched exactly. The per-test checks count the pulses and read the held pair during the trailing idle slot, several edges after the last pulse.

// File: rtl/sa_rx_pkg.sv
package sa_rx_pkg;
  localparam int SAMPLE_W = 24;

  typedef enum logic {
    FMT_I2S  = 1'b0,
    FMT_LSBJ = 1'b1
  } fmt_e;

  typedef enum logic [1:0] {
    WL16 = 2'd0,
    WL18 = 2'd1,
    WL20 = 2'd2,
    WL24 = 2'd3
  } wlen_e;

  function automatic int wlen_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/sa_rx_rst_sync.sv
module sa_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sa_rx_capture.sv
module sa_rx_capture
  import sa_rx_pkg::*;
#(
  parameter int OUT_W = SAMPLE_W,
  parameter int CW    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ws_i,
  input  logic             sd_i,
  input  logic             fmt_i,
  input  logic [1:0]       wlen_i,
  output logic             done_o,
  output logic             chan_o,
  output logic [OUT_W-1:0] word_o,
  output logic [CW-1:0]    len_o
);
  logic             primed_q, primed_n;
  logic             ws_q, ws_n;
  logic             sync_q, sync_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [OUT_W-1:0] sh_q, sh_n;
  logic [OUT_W-1:0] acc_q, acc_n;
  logic [OUT_W-1:0] acc_ins, word_lsb;
  logic             ws_edge;
  int               nbits;

  always_comb begin
    nbits   = wlen_bits(wlen_i);
    ws_edge = primed_q && (ws_i != ws_q);

    // Delayed-MSB path: the current bit lands at its position counted from the MSB.
    acc_ins = acc_q;
    for (int i = 0; i < OUT_W; i++) begin
      if (i < nbits && int'(cnt_q) == i) acc_ins[OUT_W-1-i] = sd_i;
    end

    // LSB-justified path: the last nbits of the shift history, left-aligned.
    word_lsb = '0;
    for (int i = 0; i < OUT_W; i++) begin
      for (int j = 0; j < OUT_W; j++) begin
        if (i < nbits && j == nbits - 1 - i) word_lsb[OUT_W-1-i] = sh_q[j];
      end
    end
  end

  assign word_o = (fmt_i == FMT_LSBJ) ? word_lsb : acc_ins;
  assign done_o = ws_edge && sync_q;
  assign chan_o = ws_q;
  assign len_o  = cnt_q;

  always_comb begin
    primed_n = 1'b1;
    ws_n     = ws_i;
    sync_n   = sync_q | ws_edge;
    sh_n     = {sh_q[OUT_W-2:0], sd_i};
    if (ws_edge) begin
      cnt_n = '0;
      acc_n = '0;
    end else begin
      cnt_n = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
      acc_n = acc_ins;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      ws_q     <= 1'b0;
      sync_q   <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      acc_q    <= '0;
    end else begin
      primed_q <= primed_n;
      ws_q     <= ws_n;
      sync_q   <= sync_n;
      cnt_q    <= cnt_n;
      sh_q     <= sh_n;
      acc_q    <= acc_n;
    end
  end

  // R4
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && wlen_i == WL16) |-> (word_o[OUT_W-17:0] == '0));

  // R6
  sync_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(primed_q));
endmodule

// File: rtl/sa_rx_pair.sv
module sa_rx_pair #(
  parameter int OUT_W    = 24,
  parameter int CW       = 7,
  parameter int MAX_SLOT = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             chan_i,
  input  logic [OUT_W-1:0] word_i,
  input  logic [CW-1:0]    len_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic             err_o
);
  logic [OUT_W-1:0] lhold_q, left_q, right_q;
  logic [CW-1:0]    llen_q;
  logic             lok_q, lok_n, valid_q, err_q, err_n;
  logic             ld_left, ld_frame, over_l, over_r;

  always_comb begin
    ld_left  = done_i && !chan_i;
    ld_frame = done_i && chan_i && lok_q;
    over_l   = int'(llen_q) >= MAX_SLOT;
    over_r   = int'(len_i) >= MAX_SLOT;
    err_n    = over_l || over_r || (llen_q != len_i);
    if (ld_left)       lok_n = 1'b1;
    else if (ld_frame) lok_n = 1'b0;
    else               lok_n = lok_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lhold_q <= '0;
      llen_q  <= '0;
      lok_q   <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      lok_q   <= lok_n;
      valid_q <= ld_frame;
      if (ld_left) begin
        lhold_q <= word_i;
        llen_q  <= len_i;
      end
      if (ld_frame) begin
        left_q  <= lhold_q;
        right_q <= word_i;
        err_q   <= err_n;
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R6
  valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(done_i && chan_i));

  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(err_q));

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> ($stable(left_q) && $stable(right_q)));
endmodule

// File: rtl/sa_rx.sv
module sa_rx
  import sa_rx_pkg::*;
#(
  parameter int MAX_SLOT = 32
) (
  input  logic                bck_i,
  input  logic                rst_ni,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic                fmt_i,
  input  logic [1:0]          wlen_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                frame_err_o
);
  localparam int CW = $clog2(MAX_SLOT) + 2;

  logic                rst_s_n;
  logic                done, chan;
  logic [SAMPLE_W-1:0] word;
  logic [CW-1:0]       len;

  sa_rx_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (bck_i),
    .arst_ni(rst_ni),
    .rst_no (rst_s_n)
  );

  sa_rx_capture #(.OUT_W(SAMPLE_W), .CW(CW)) u_cap (
    .clk_i (bck_i),
    .rst_ni(rst_s_n),
    .ws_i  (ws_i),
    .sd_i  (sd_i),
    .fmt_i (fmt_i),
    .wlen_i(wlen_i),
    .done_o(done),
    .chan_o(chan),
    .word_o(word),
    .len_o (len)
  );

  sa_rx_pair #(.OUT_W(SAMPLE_W), .CW(CW), .MAX_SLOT(MAX_SLOT)) u_pair (
    .clk_i  (bck_i),
    .rst_ni (rst_s_n),
    .done_i (done),
    .chan_i (chan),
    .word_i (word),
    .len_i  (len),
    .left_o (left_o),
    .right_o(right_o),
    .valid_o(valid_o),
    .err_o  (frame_err_o)
  );
endmodule

// File: tb/sim_sa_rx.sv
module sim_sa_rx;
  logic        clk = 1'b0;
  logic        rst_n, ws, sd, fmt;
  logic [1:0]  wlen;
  logic [23:0] left_o, right_o;
  logic        valid_o, frame_err_o;

  int checks = 0, fails = 0, nvalid = 0;
  logic [23:0] gl, gr;
  logic ge, fe;
  string cur_req = "R1";
  bit finished = 0;
  bit wsq[$];
  bit dq[$];

  // reference model state
  bit hist[$];
  bit slotq[$];
  bit prev_ws, synced, lok, ev, ee;
  logic [23:0] lw, el, er;
  int ll;

  always #5 clk = ~clk;

  sa_rx u0 (
    .bck_i(clk), .rst_ni(rst_n), .ws_i(ws), .sd_i(sd), .fmt_i(fmt),
    .wlen_i(wlen), .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .frame_err_o(frame_err_o)
  );

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 18 : (s == 2'd2) ? 20 : 24;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete(); slotq.delete();
      prev_ws = ws; synced = 0; lok = 0; ev = 0; ee = 0;
      lw = '0; el = '0; er = '0; ll = 0;
    end else begin
      automatic int n = nb(wlen);
      automatic logic [23:0] w = '0;
      automatic int len;
      ev = 0;
      if (ws != prev_ws) begin
        if (fmt == 1'b0) slotq.push_back(sd);
        len = slotq.size();
        for (int i = 0; i < n; i++) begin
          if (fmt == 1'b0) begin
            if (i < len) w[23-i] = slotq[i];
          end else begin
            automatic int k = hist.size() - n + i;
            if (k >= 0) w[23-i] = hist[k];
          end
        end
        if (synced) begin
          if (prev_ws == 1'b0) begin
            lw = w; ll = len; lok = 1;
          end else if (lok) begin
            ev = 1; el = lw; er = w; lok = 0;
            ee = (ll > 32) || (len > 32) || (ll != len);
          end
        end
        synced = 1;
        slotq.delete();
        if (fmt == 1'b1) slotq.push_back(sd);
      end else begin
        slotq.push_back(sd);
      end
      hist.push_back(sd);
      prev_ws = ws;
    end
    #2;
    if (!finished) begin
      checks++;
      if (valid_o !== ev || left_o !== el || right_o !== er || frame_err_o !== ee) begin
        fails++;
        $display("FAIL %s cycle model: got v=%b l=%h r=%h e=%b exp v=%b l=%h r=%h e=%b",
                 cur_req, valid_o, left_o, right_o, frame_err_o, ev, el, er, ee);
      end
      if (valid_o === 1'b1) begin
        if (nvalid == 0) fe = frame_err_o;
        nvalid++; gl = left_o; gr = right_o; ge = frame_err_o;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic start(input logic f, input logic [1:0] wl, input string req);
    @(negedge clk);
    rst_n = 0; ws = 1; sd = 0; fmt = f; wlen = wl; cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1 reset left", {8'h0, left_o}, 0);
    chk("R1 reset flags", {30'h0, valid_o, frame_err_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {8'h0, right_o}, 0);
    nvalid = 0; fe = 0;
    wsq.delete(); dq.delete();
    cur_req = req;
  endtask

  task automatic add_slot(input bit w, input logic [63:0] v, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      wsq.push_back(w);
      dq.push_back(v[i]);
    end
  endtask

  task automatic play();
    add_slot(1'b0, 64'h0, 4);
    for (int t = 0; t < wsq.size(); t++) begin
      @(negedge clk);
      ws = wsq[t];
      sd = fmt ? dq[t] : ((t > 0) ? dq[t-1] : 1'b0);
    end
    repeat (6) begin
      @(negedge clk);
      sd = 0;
    end
  endtask

  task automatic expect_frames(input string req, input int n, input logic [23:0] l,
                               input logic [23:0] r, input bit e);
    chk({req, " valid count R6"}, nvalid, n);
    chk({req, " left R8"}, {8'h0, left_o}, {8'h0, l});
    chk({req, " right"}, {8'h0, right_o}, {8'h0, r});
    chk({req, " err R7"}, {31'h0, frame_err_o}, {31'h0, e});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ws = 1; sd = 0; fmt = 0; wlen = 2'd3;

    // R2 R5: delayed-MSB framing, 32-bit slots, 24-bit words
    start(1'b0, 2'd3, "R2 R5 R6");
    add_slot(0, 64'hC3A55A96, 32); add_slot(1, 64'h12345678, 32);
    add_slot(0, 64'h80000001, 32); add_slot(1, 64'h7FFFFFFE, 32);
    play();
    expect_frames("R2", 2, 24'h800000, 24'h7FFFFF, 0);

    // R4: 16-bit words in 32-bit slots
    start(1'b0, 2'd0, "R4 R5");
    add_slot(0, 64'hBEEF1234, 32); add_slot(1, 64'hCAFEFFFF, 32);
    play();
    expect_frames("R4 16b", 1, 24'hBEEF00, 24'hCAFE00, 0);

    // R4: 18-bit words in exact 18-bit slots
    start(1'b0, 2'd1, "R4");
    add_slot(0, 64'h2ABCD, 18); add_slot(1, 64'h15555, 18);
    play();
    expect_frames("R4 18b", 1, 24'hAAF340, 24'h555540, 0);

    // R3: LSB-justified 20-bit words in 32-bit slots
    start(1'b1, 2'd2, "R3 R4");
    add_slot(0, 64'hFFF98765, 32); add_slot(1, 64'h00012345, 32);
    play();
    expect_frames("R3 20b", 1, 24'h987650, 24'h123450, 0);

    // R3: LSB-justified 24-bit words in 24-bit slots
    start(1'b1, 2'd3, "R3");
    add_slot(0, 64'hA1B2C3, 24); add_slot(1, 64'h5D6E7F, 24);
    add_slot(0, 64'h000001, 24); add_slot(1, 64'h800000, 24);
    play();
    expect_frames("R3 24b", 2, 24'h000001, 24'h800000, 0);

    // R7: unequal slots flag an error, a following good frame clears it
    start(1'b0, 2'd3, "R7 R8");
    add_slot(0, 64'hFFFFFFFF, 32); add_slot(1, 64'h15555555, 30);
    add_slot(0, 64'h11223344, 32); add_slot(1, 64'h55667788, 32);
    play();
    chk("R7 unequal slots err", {31'h0, fe}, 1);
    expect_frames("R7 clear", 2, 24'h112233, 24'h556677, 0);

    // R5 R7: 40-bit slots exceed the limit, words truncated to the MSBs
    start(1'b0, 2'd3, "R5 R7");
    add_slot(0, 64'hF012345678, 40); add_slot(1, 64'h0ABCDEF012, 40);
    play();
    expect_frames("R5 long", 1, 24'hF01234, 24'h0ABCDE, 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule